// File: doc/BRIEF.md
# Luhn check digit unit

This block runs the mod-10 weighted checksum used on card and equipment identity numbers, one decimal digit per cycle. Digits come in as 4-bit BCD values, rightmost digit first. Each digit has a valid strobe, and the final digit of a number also carries a last flag. Every second digit is doubled, and a doubled value of ten or more is folded back to a single digit. The folded contributions are summed modulo 10 in a 4-bit accumulator.

The mode is taken from `mode_verify` on the first digit of each number. In generate mode (0) the digits form a payload, and the block returns the check digit that makes the whole number a multiple of ten. In verify mode (1) the first digit received is the check digit itself, and the block reports whether the complete number passes. A result appears on the cycle after the last digit, and the accumulator is then ready for the next number with no idle cycle between numbers. A non-BCD input value, or a number longer than the configured maximum, marks the result as an error.

Top module: `luhn_check_unit`

## Requirements
- R1: In generate mode (`mode_verify`=0 on the first digit), the first digit received and every second digit after it are doubled. `res_check` equals (10 - S mod 10) mod 10, where S is the sum of all contributions.
- R2: In verify mode (`mode_verify`=1 on the first digit), the first digit is not doubled, the second is, and so on alternately. `res_pass` is 1 exactly when S is a multiple of ten. `res_check` then carries (10 - S mod 10) mod 10, so it is 0 on a pass.
- R3: A doubled digit whose double is 10 or more contributes the double minus 9. For example, 5 contributes 1 and 9 contributes 9.
- R4: `mode_verify` is sampled only with the first digit of a number. Changing it on later digits of the same number has no effect on the result.
- R5: `res_valid` pulses high for one cycle on the cycle after each digit that has `digit_valid`=1 and `digit_last`=1, and at no other time.
- R6: After a result, the accumulated state clears. The next number may start on the very next cycle and is evaluated independently.
- R7: A digit value above 9 sets an error that holds until the end of the number. The result then has `res_error`=1, `res_pass`=0 and `res_check`=0.
- R8: A number with more than MAX_DIGITS digits (default 32) is reported with `res_error`=1. A number of exactly MAX_DIGITS digits is not.
- R9: Cycles with `digit_valid`=0 are ignored. Gaps between the digits of a number leave its result unchanged.
- R10: Synchronous active-high `rst` clears the outputs to zero and discards any partly received number.
- R11: While `res_valid` is 0, `res_check`, `res_pass` and `res_error` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| digit_valid | input | 1 | Digit strobe |
| digit_in | input | 4 | BCD digit, rightmost digit of the number first |
| digit_last | input | 1 | Marks the final digit of a number |
| mode_verify | input | 1 | 0 = generate check digit, 1 = verify number; sampled on the first digit |
| res_valid | output | 1 | One-cycle result strobe |
| res_check | output | 4 | Check digit (10 - S mod 10) mod 10 |
| res_pass | output | 1 | Verify mode: number is valid |
| res_error | output | 1 | Bad digit or over-length number |

## Verification
The assertions check, on every cycle, the structural behaviour of the block:
- the result strobe follows each last digit exactly one cycle later and appears at no other time;
- the result fields stay zero between strobes;
- an error suppresses pass;
- the accumulator stays below ten and is clear after each number.

Only the bench's reference model can show the arithmetic. That covers the doubling parity in each mode, the fold of doubled values, the latching of the mode on the first digit, the length limit at MAX_DIGITS and one digit beyond it, and independence across back-to-back numbers, gaps and a reset in the middle of a number.

// File: rtl/luhn_pkg.sv
package luhn_pkg;

    typedef logic [3:0] bcd_t;

    typedef enum logic {
        MODE_GEN = 1'b0,
        MODE_VER = 1'b1
    } luhn_mode_e;

    // one incoming beat
    typedef struct packed {
        logic       valid;
        logic       last;
        bcd_t       digit;
        luhn_mode_e mode;
    } digit_beat_t;

    // weighted contribution of one digit
    typedef struct packed {
        logic bad;
        bcd_t contrib;
    } term_t;

    // end-of-number summary handed to the output stage
    typedef struct packed {
        logic       fire;
        bcd_t       sum;
        logic       err;
        luhn_mode_e mode;
    } finish_t;

    typedef struct packed {
        logic valid;
        bcd_t check;
        logic pass;
        logic error;
    } result_t;

    localparam bcd_t BCD_MAX = 4'd9;

    // doubled digit folded back to one decimal digit
    function automatic bcd_t fold_double(input bcd_t d);
        logic [4:0] t;
        t = {d, 1'b0};
        if (t > 5'd9) t = t - 5'd9;
        return t[3:0];
    endfunction

    function automatic bcd_t add_mod10(input bcd_t a, input bcd_t b);
        logic [4:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= 5'd10) s = s - 5'd10;
        return s[3:0];
    endfunction

    function automatic bcd_t complement_mod10(input bcd_t s);
        return (s == 4'd0) ? 4'd0 : (4'd10 - s);
    endfunction

endpackage

// File: rtl/luhn_term.sv
module luhn_term
    import luhn_pkg::*;
(
    input  bcd_t  digit_i,
    input  logic  dbl_i,
    output term_t term_o
);
    logic bad;

    assign bad = (digit_i > BCD_MAX);

    always_comb begin
        term_o.bad = bad;
        if (bad)
            term_o.contrib = 4'd0;
        else if (dbl_i)
            term_o.contrib = fold_double(digit_i);
        else
            term_o.contrib = digit_i;
    end
endmodule

// File: rtl/luhn_accum.sv
module luhn_accum
    import luhn_pkg::*;
#(
    parameter int MAX_DIGITS = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  digit_beat_t beat_i,
    input  term_t       term_i,
    output logic        dbl_o,
    output bcd_t        sum_o,
    output finish_t     fin_o
);
    localparam int CNT_W = $clog2(MAX_DIGITS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_DIGITS);

    bcd_t             sum_q, sum_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             err_q, err_n;
    luhn_mode_e       mode_q, mode_eff;
    logic             first;
    logic             over_len;

    assign first    = (cnt_q == '0);
    assign mode_eff = first ? beat_i.mode : mode_q;
    assign over_len = (cnt_q == CNT_MAX);

    // verify: check digit (pos 0) plain, odd positions doubled; generate: even positions doubled
    assign dbl_o = (mode_eff == MODE_VER) ? cnt_q[0] : ~cnt_q[0];
    assign sum_o = sum_q;

    always_comb begin
        sum_n = add_mod10(sum_q, term_i.contrib);
        err_n = err_q | term_i.bad | over_len;
        cnt_n = over_len ? cnt_q : cnt_q + 1'b1;
    end

    always_comb begin
        fin_o.fire = beat_i.valid & beat_i.last;
        fin_o.sum  = sum_n;
        fin_o.err  = err_n;
        fin_o.mode = mode_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q  <= '0;
            cnt_q  <= '0;
            err_q  <= 1'b0;
            mode_q <= MODE_GEN;
        end else if (beat_i.valid) begin
            if (beat_i.last) begin
                sum_q  <= '0;
                cnt_q  <= '0;
                err_q  <= 1'b0;
                mode_q <= MODE_GEN;
            end else begin
                sum_q  <= sum_n;
                cnt_q  <= cnt_n;
                err_q  <= err_n;
                mode_q <= mode_eff;
            end
        end
    end
endmodule

// File: rtl/luhn_result.sv
module luhn_result
    import luhn_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  finish_t fin_i,
    output result_t res_o
);
    result_t res_n;

    always_comb begin
        res_n = '0;
        if (fin_i.fire) begin
            res_n.valid = 1'b1;
            res_n.error = fin_i.err;
            if (!fin_i.err) begin
                res_n.check = complement_mod10(fin_i.sum);
                res_n.pass  = (fin_i.mode == MODE_VER) && (fin_i.sum == 4'd0);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_o <= '0;
        else     res_o <= res_n;
    end
endmodule

// File: rtl/luhn_check_unit.sv
module luhn_check_unit
    import luhn_pkg::*;
#(
    parameter int MAX_DIGITS = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       digit_valid,
    input  logic [3:0] digit_in,
    input  logic       digit_last,
    input  logic       mode_verify,
    output logic       res_valid,
    output logic [3:0] res_check,
    output logic       res_pass,
    output logic       res_error
);
    digit_beat_t beat;
    term_t       term;
    finish_t     fin;
    result_t     res;
    logic        dbl;
    bcd_t        acc_sum;

    always_comb begin
        beat.valid = digit_valid;
        beat.last  = digit_last;
        beat.digit = digit_in;
        beat.mode  = mode_verify ? MODE_VER : MODE_GEN;
    end

    luhn_term u_term (
        .digit_i (beat.digit),
        .dbl_i   (dbl),
        .term_o  (term)
    );

    luhn_accum #(.MAX_DIGITS(MAX_DIGITS)) u_accum (
        .clk    (clk),
        .rst    (rst),
        .beat_i (beat),
        .term_i (term),
        .dbl_o  (dbl),
        .sum_o  (acc_sum),
        .fin_o  (fin)
    );

    luhn_result u_result (
        .clk   (clk),
        .rst   (rst),
        .fin_i (fin),
        .res_o (res)
    );

    assign res_valid = res.valid;
    assign res_check = res.check;
    assign res_pass  = res.pass;
    assign res_error = res.error;
endmodule

// File: rtl/luhn_check_unit_chk.sv
module luhn_check_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       digit_valid,
    input logic [3:0] digit_in,
    input logic       digit_last,
    input logic       res_valid,
    input logic [3:0] res_check,
    input logic       res_pass,
    input logic       res_error,
    input logic [3:0] acc_sum
);
    assert_valid_follows_last_R5: assert property (@(posedge clk) disable iff (rst)
        (digit_valid && digit_last) |=> res_valid);

    assert_no_spurious_valid_R5: assert property (@(posedge clk) disable iff (rst)
        !(digit_valid && digit_last) |=> !res_valid);

    assert_bad_digit_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (digit_valid && digit_last && digit_in > 4'd9) |=> res_error);

    assert_error_blocks_pass_R7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_error) |-> (!res_pass && res_check == 4'd0));

    assert_idle_outputs_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (!res_pass && !res_error && res_check == 4'd0));

    assert_check_range_R1: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_check <= 4'd9));

    assert_pass_zero_check_R2: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_pass) |-> (res_check == 4'd0));

    assert_acc_below_ten_R6: assert property (@(posedge clk) disable iff (rst)
        acc_sum < 4'd10);

    assert_acc_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (digit_valid && digit_last) |=> (acc_sum == 4'd0));
endmodule

bind luhn_check_unit luhn_check_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .digit_valid (digit_valid),
    .digit_in    (digit_in),
    .digit_last  (digit_last),
    .res_valid   (res_valid),
    .res_check   (res_check),
    .res_pass    (res_pass),
    .res_error   (res_error),
    .acc_sum     (acc_sum)
);

// File: tb/luhn_check_unit_bench.sv
`timescale 1ns/1ps
module luhn_check_unit_bench;
    localparam int MAXD = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dv = 1'b0;
    logic [3:0] di = 4'd0;
    logic       dl = 1'b0;
    logic       mv = 1'b0;
    logic       res_valid, res_pass, res_error;
    logic [3:0] res_check;

    int compared = 0;
    int mismatched = 0;
    string tag = "R10";

    // behavioural model state
    int m_sum = 0;
    int m_pos = 0;
    bit m_err = 0;
    bit m_mode = 0;
    bit e_valid = 0, e_pass = 0, e_err = 0;
    int e_check = 0;
    int seq[$];
    int unsigned seed = 32'h1234_5678;

    luhn_check_unit #(.MAX_DIGITS(MAXD)) u_luhn_check_unit (
        .clk(clk), .rst(rst), .digit_valid(dv), .digit_in(di), .digit_last(dl),
        .mode_verify(mv), .res_valid(res_valid), .res_check(res_check),
        .res_pass(res_pass), .res_error(res_error)
    );

    always #2.5 clk = ~clk;

    task automatic compare();
        compared++;
        if (res_valid !== e_valid || res_check !== 4'(e_check) ||
            res_pass !== e_pass || res_error !== e_err) begin
            mismatched++;
            $display("FAIL %s t=%0t actual v=%0b chk=%0d pass=%0b err=%0b expected v=%0b chk=%0d pass=%0b err=%0b",
                     tag, $time, res_valid, res_check, res_pass, res_error,
                     e_valid, e_check, e_pass, e_err);
        end
    endtask

    task automatic model(input bit r, input bit v, input int d, input bit l, input bit m);
        bit dbl;
        int c;
        e_valid = 0; e_pass = 0; e_err = 0; e_check = 0;
        if (r) begin
            m_sum = 0; m_pos = 0; m_err = 0; m_mode = 0;
            return;
        end
        if (!v) return;
        if (m_pos == 0) m_mode = m;
        dbl = m_mode ? (m_pos % 2 == 1) : (m_pos % 2 == 0);
        if (m_pos >= MAXD) m_err = 1;
        if (d > 9) m_err = 1;
        else begin
            c = dbl ? 2 * d : d;
            if (c > 9) c = c - 9;
            m_sum += c;
        end
        m_pos++;
        if (l) begin
            e_valid = 1;
            e_err = m_err;
            if (!m_err) begin
                e_check = (10 - (m_sum % 10)) % 10;
                e_pass = m_mode && (m_sum % 10 == 0);
            end
            m_sum = 0; m_pos = 0; m_err = 0; m_mode = 0;
        end
    endtask

    task automatic step(input bit r, input bit v, input int d, input bit l, input bit m);
        @(negedge clk);
        compare();
        rst = r; dv = v; di = 4'(d); dl = l; mv = m;
        model(r, v, d, l, m);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
    endtask

    task automatic send(input bit m, input int gap);
        for (int i = 0; i < seq.size(); i++) begin
            step(0, 1, seq[i], i == seq.size() - 1, m);
            if (gap > 0 && i != seq.size() - 1) idle(gap);
        end
    endtask

    function automatic int rnd(input int n);
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 8) % n);
    endfunction

    initial begin
        // R10: reset state
        tag = "R10";
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0);
        idle(2);

        // R1: generate check digit for a known payload (expected 3)
        tag = "R1";
        seq = {1, 7, 8, 9, 3, 7, 2, 9, 9, 7};
        send(0, 0); idle(2);

        // R3: fold of doubled values (5 -> 1, 9 -> 9)
        tag = "R3";
        seq = {5};       send(0, 0); idle(1);
        seq = {9, 9};    send(0, 0); idle(1);
        seq = {6, 0, 7}; send(0, 0); idle(1);

        // R2: verify a passing and a failing number
        tag = "R2";
        seq = {3, 1, 7, 8, 9, 3, 7, 2, 9, 9, 7}; send(1, 0); idle(1);
        seq = {0, 1, 7, 8, 9, 3, 7, 2, 9, 9, 7}; send(1, 0); idle(1);
        seq = {0};                               send(1, 0); idle(1);

        // R4: mode changes after the first digit are ignored
        tag = "R4";
        for (int i = 0; i < 6; i++) step(0, 1, i + 2, i == 5, (i % 2) == 1);
        idle(1);
        for (int i = 0; i < 5; i++) step(0, 1, 9 - i, i == 4, (i == 0));
        idle(1);

        // R9: gaps inside a number
        tag = "R9";
        seq = {3, 1, 7, 8, 9, 3, 7, 2, 9, 9, 7}; send(1, 2); idle(1);

        // R6: back-to-back numbers
        tag = "R6";
        seq = {4, 4}; send(0, 0);
        seq = {8};    send(1, 0);
        seq = {2, 6}; send(0, 0);
        idle(2);

        // R7: bad digit, then a clean number
        tag = "R7";
        seq = {4, 12, 3}; send(0, 0);
        seq = {15};       send(1, 0);
        seq = {7, 1};     send(0, 0);
        idle(2);

        // R8: length limit at and beyond MAX_DIGITS
        tag = "R8";
        seq.delete();
        for (int i = 0; i < MAXD; i++) seq.push_back(i % 10);
        send(0, 0); idle(1);
        seq.push_back(4);
        send(0, 0); idle(1);
        seq = {1, 2};
        send(1, 0); idle(1);

        // R10: reset in the middle of a number
        tag = "R10";
        step(0, 1, 7, 0, 1);
        step(0, 1, 3, 0, 1);
        step(1, 0, 0, 0, 0);
        seq = {5, 5}; send(0, 0); idle(2);

        // R11: random traffic, result fields idle between strobes
        tag = "R11";
        for (int n = 0; n < 40; n++) begin
            int len;
            len = 1 + rnd(12);
            seq.delete();
            for (int k = 0; k < len; k++) seq.push_back(rnd(16) == 0 ? 10 + rnd(6) : rnd(10));
            send(rnd(2) == 1, rnd(3) == 0 ? 1 : 0);
            idle(rnd(3));
        end
        idle(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        mismatched++;
        $display("FAIL R5 watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule